// File: doc/BRIEF.md
# Nested Preemptive Abort Controller

This block keeps track of up to four nested abort regions for a pipelined processor core. Each time the core executes an abort instruction it asks the controller to open a new, inner level. That level records two things taken from fixed fields of the instruction word: the number of the external input it watches and the program address at which the region ends. While a level is open, the controller watches for two ways it can close. A preemptive close happens when the watched input goes high. A normal close happens when the program counter reaches the stored address. Closing a level also discards every level nested inside it.

When several open levels close in the same cycle, the outermost one wins. On a preemptive close the controller raises a one-cycle pending-abort flag and presents the stored address of the winning level. The core then loads that address into its program counter and restarts its pipeline; no return context is kept. A normal close only shrinks the nesting depth.

The nesting depth is reported as a small count. A full indicator tells the core that no further level can be opened.

Top module: `abort_nest_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, depth is 0, full is 0, the pending-abort flag is 0, and the continuation address is 0.
- R2: A load request at depth k below four, in a cycle with no close, makes depth k+1 on the next cycle. The new level takes its input index from abortWord[8:5] and its address from abortWord[24:9]. Bits 4:0 are ignored.
- R3: An open level closes preemptively when sigIn bit number (its stored index) is 1. Depth then becomes the number of levels outside it.
- R4: An open level closes normally when pcValue equals its stored address. Depth then becomes the number of levels outside it, and the pending-abort flag stays 0.
- R5: When several open levels close in one cycle, only the outermost one counts. Whether the flag is raised depends only on the kind of close that level saw.
- R6: A preemptive close raises pendAbort for exactly the following cycle. In that cycle contAddr holds the closed level's stored address, and contAddr keeps that value until the next preemptive close.
- R7: full is 1 exactly when depth is four. A load request while full leaves depth unchanged.
- R8: A load request in a cycle in which any open level closes is ignored; only the close takes effect.
- R9: A level loaded in a cycle cannot close in that same cycle. Its close conditions are checked from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| loadReq | input | 1 | Open a new nested level from abortWord |
| abortWord | input | 25 | Low bits of the abort instruction: [24:9] address, [8:5] input index |
| sigIn | input | 16 | External event inputs watched by open levels |
| pcValue | input | 16 | Current program counter, compared with stored addresses |
| pendAbort | output | 1 | One-cycle pulse: jump to contAddr |
| contAddr | output | 16 | Continuation address of the last preemptive close |
| full | output | 1 | Every level is in use |
| depth | output | 3 | Number of open levels, 0 to 4 |

## Verification
The checker assumes that loadReq, sigIn and pcValue carry defined values on every clock edge. It also assumes that loadReq may be asserted at any depth, including when full, so it checks only that depth grows by at most one and never grows without a request. The stimulus drives every input on each cycle, keeps sigIn mostly quiet so that four-deep nesting is reached often, and steers pcValue onto a stored address now and then so that normal closes and mixed closes take place.

// File: rtl/abort_nest_pkg.sv
package abort_nest_pkg;
  // widest level select carried in the strobe struct (up to 16 levels)
  localparam int unsigned SEL_W = 4;

  typedef struct packed {
    logic             wrEn;    // write the level named by wrLvl
    logic [SEL_W-1:0] wrLvl;
    logic             capEn;   // capture that level's address as continuation
    logic [SEL_W-1:0] capLvl;
  } lvl_strb_t;
endpackage

// File: rtl/abort_nest_dp.sv
module abort_nest_dp
  import abort_nest_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned SIG_N  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_LSB = 5,
  localparam int unsigned IDX_W  = $clog2(SIG_N),
  localparam int unsigned ADDR_LSB = IDX_LSB + IDX_W,
  localparam int unsigned WORD_W = ADDR_LSB + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lvl_strb_t         strb,
  input  logic [WORD_W-1:0] abortWord,
  input  logic [SIG_N-1:0]  sigIn,
  input  logic [ADDR_W-1:0] pcValue,
  output logic [LEVELS-1:0] endPre,
  output logic [LEVELS-1:0] endNorm,
  output logic [ADDR_W-1:0] contAddr
);
  logic [IDX_W-1:0]  lvlIdx  [LEVELS];
  logic [ADDR_W-1:0] lvlAddr [LEVELS];
  logic [IDX_W-1:0]  newIdx;
  logic [ADDR_W-1:0] newAddr;
  logic [ADDR_W-1:0] capSel;

  assign newIdx  = abortWord[ADDR_LSB-1:IDX_LSB];
  assign newAddr = abortWord[WORD_W-1:ADDR_LSB];

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvlIdx[i]  <= '0;
        lvlAddr[i] <= '0;
      end else if (strb.wrEn && strb.wrLvl == SEL_W'(i)) begin
        lvlIdx[i]  <= newIdx;
        lvlAddr[i] <= newAddr;
      end
    end
    assign endPre[i]  = sigIn[lvlIdx[i]];
    assign endNorm[i] = (pcValue == lvlAddr[i]);
  end

  always_comb begin
    capSel = '0;
    for (int i = 0; i < LEVELS; i++)
      if (strb.capLvl == SEL_W'(i)) capSel = lvlAddr[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          contAddr <= '0;
    else if (strb.capEn) contAddr <= capSel;
  end
endmodule

// File: rtl/abort_nest_ctl.sv
module abort_nest_ctl
  import abort_nest_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned DEPTH_W = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadReq,
  input  logic [LEVELS-1:0]  endPre,
  input  logic [LEVELS-1:0]  endNorm,
  output lvl_strb_t          strb,
  output logic [DEPTH_W-1:0] depth,
  output logic               full,
  output logic               pendAbort
);
  logic [LEVELS-1:0]  activeMask;
  logic [LEVELS-1:0]  hitMask;
  logic               anyHit;
  logic               hitPre;
  logic [SEL_W-1:0]   hitLvl;
  logic [DEPTH_W-1:0] depthNext;
  logic               pendNext;

  for (genvar i = 0; i < LEVELS; i++) begin : g_act
    assign activeMask[i] = DEPTH_W'(i) < depth;
  end

  assign hitMask = (endPre | endNorm) & activeMask;
  assign full    = (depth == DEPTH_W'(LEVELS));

  // innermost first so the outermost hit is the one left standing
  always_comb begin
    anyHit = 1'b0;
    hitPre = 1'b0;
    hitLvl = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (hitMask[i]) begin
        anyHit = 1'b1;
        hitPre = endPre[i];
        hitLvl = SEL_W'(i);
      end
    end
  end

  always_comb begin
    strb      = '0;
    depthNext = depth;
    pendNext  = 1'b0;
    if (anyHit) begin
      depthNext   = DEPTH_W'(hitLvl);
      pendNext    = hitPre;
      strb.capEn  = hitPre;
      strb.capLvl = hitLvl;
    end else if (loadReq && !full) begin
      depthNext  = depth + 1'b1;
      strb.wrEn  = 1'b1;
      strb.wrLvl = SEL_W'(depth);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth     <= '0;
      pendAbort <= 1'b0;
    end else begin
      depth     <= depthNext;
      pendAbort <= pendNext;
    end
  end
endmodule

// File: rtl/abort_nest_top.sv
module abort_nest_top
  import abort_nest_pkg::*;
#(
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned SIG_N   = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IDX_LSB = 5,
  localparam int unsigned DEPTH_W = $clog2(LEVELS + 1),
  localparam int unsigned WORD_W  = IDX_LSB + $clog2(SIG_N) + ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadReq,
  input  logic [WORD_W-1:0]  abortWord,
  input  logic [SIG_N-1:0]   sigIn,
  input  logic [ADDR_W-1:0]  pcValue,
  output logic               pendAbort,
  output logic [ADDR_W-1:0]  contAddr,
  output logic               full,
  output logic [DEPTH_W-1:0] depth
);
  lvl_strb_t         strb;
  logic [LEVELS-1:0] endPre;
  logic [LEVELS-1:0] endNorm;

  abort_nest_ctl #(.LEVELS(LEVELS)) u_ctl (
    .clk(clk), .rstN(rstN), .loadReq(loadReq),
    .endPre(endPre), .endNorm(endNorm), .strb(strb),
    .depth(depth), .full(full), .pendAbort(pendAbort)
  );

  abort_nest_dp #(
    .LEVELS(LEVELS), .SIG_N(SIG_N), .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .abortWord(abortWord),
    .sigIn(sigIn), .pcValue(pcValue),
    .endPre(endPre), .endNorm(endNorm), .contAddr(contAddr)
  );
endmodule

// File: rtl/abort_nest_chk.sv
module abort_nest_chk #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned DEPTH_W = $clog2(LEVELS + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadReq,
  input logic               pendAbort,
  input logic [ADDR_W-1:0]  contAddr,
  input logic               full,
  input logic [DEPTH_W-1:0] depth
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (depth == '0 && !pendAbort && contAddr == '0));

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(LEVELS));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && loadReq) |=> depth <= $past(depth));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (depth < DEPTH_W'(LEVELS)) |=> ({1'b0, depth} <= {1'b0, $past(depth)} + 1'b1));

  p_grow_needs_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadReq |=> depth <= $past(depth));

  p_flag_pops_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendAbort |-> depth < $past(depth));

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pendAbort |-> $stable(contAddr));
endmodule

bind abort_nest_top abort_nest_chk #(.LEVELS(LEVELS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadReq(loadReq), .pendAbort(pendAbort),
  .contAddr(contAddr), .full(full), .depth(depth)
);

// File: tb/tb_abort_nest_top.sv
`timescale 1ns/1ps
module tb_abort_nest_top;
  localparam int LV = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadReq;
  logic [24:0] abortWord;
  logic [15:0] sigIn;
  logic [15:0] pcValue;
  logic        pendAbort;
  logic [15:0] contAddr;
  logic        full;
  logic [2:0]  depth;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state built from the requirements
  int          mDepth;
  logic [3:0]  mIdx  [LV];
  logic [15:0] mAddr [LV];
  logic        mPend;
  logic [15:0] mCont;

  always #4 clk = ~clk;

  abort_nest_top dut (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .abortWord(abortWord),
    .sigIn(sigIn), .pcValue(pcValue), .pendAbort(pendAbort),
    .contAddr(contAddr), .full(full), .depth(depth)
  );

  function automatic logic [24:0] mkWord(logic [15:0] a, logic [3:0] idx, logic [4:0] junk);
    return {a, idx, junk};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "depth", int'(depth), mDepth);
    chk(tag, "full", int'(full), int'(mDepth == LV));
    chk(tag, "pendAbort", int'(pendAbort), int'(mPend));
    chk(tag, "contAddr", int'(contAddr), int'(mCont));
  endtask

  // one cycle of the reference behaviour; returns the requirement it exercises
  task automatic modelStep(input logic ld, input logic [24:0] w, input logic [15:0] s,
                           input logic [15:0] pc, output string tag);
    int hit = -1;
    int nHits = 0;
    for (int j = LV - 1; j >= 0; j--) begin
      if (j < mDepth && (s[mIdx[j]] || pc == mAddr[j])) begin
        hit = j;
        nHits++;
      end
    end
    mPend = 1'b0;
    tag = "R2";
    if (hit >= 0) begin
      mPend = s[mIdx[hit]];
      if (mPend) mCont = mAddr[hit];
      mDepth = hit;
      tag = (nHits > 1) ? "R5" : (ld ? "R8" : (mPend ? "R3" : "R4"));
    end else if (ld) begin
      if (mDepth < LV) begin
        mIdx[mDepth]  = w[8:5];
        mAddr[mDepth] = w[24:9];
        mDepth++;
      end else tag = "R7";
    end
  endtask

  task automatic apply(logic ld, logic [24:0] w, logic [15:0] s, logic [15:0] pc, string tagIn);
    string t;
    loadReq = ld; abortWord = w; sigIn = s; pcValue = pc;
    modelStep(ld, w, s, pc, t);
    @(posedge clk); #2;
    checkAll(tagIn == "" ? t : tagIn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; loadReq = 1'b0; abortWord = '0; sigIn = '0; pcValue = 16'hffff;
    mDepth = 0; mPend = 1'b0; mCont = '0;
    for (int j = 0; j < LV; j++) begin mIdx[j] = '0; mAddr[j] = '0; end
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1");
    @(negedge clk); rstN = 1'b1;
    #1;
    checkAll("R1");

    // fill all four levels; junk in low bits must be ignored (R2)
    apply(1, mkWord(16'h1000, 4'd3, 5'h1f), 16'h0, 16'h0, "R2");
    apply(1, mkWord(16'h2000, 4'd7, 5'h0a), 16'h0, 16'h0, "R2");
    apply(1, mkWord(16'h3000, 4'd9, 5'h15), 16'h0, 16'h0, "R2");
    apply(1, mkWord(16'h4000, 4'd12, 5'h03), 16'h0, 16'h0, "R7");
    // extra load while full (R7)
    apply(1, mkWord(16'h5000, 4'd1, 5'h00), 16'h0, 16'h0, "R7");
    // preempt third level via input 9 (R3, R6)
    apply(0, '0, 16'h0200, 16'h0, "R3");
    // flag drops after one cycle (R6)
    apply(0, '0, 16'h0, 16'h0, "R6");
    // normal close of second level (R4)
    apply(0, '0, 16'h0, 16'h2000, "R4");
    apply(1, mkWord(16'h2100, 4'd5, 5'h00), 16'h0, 16'h0, "R2");
    apply(1, mkWord(16'h3100, 4'd6, 5'h00), 16'h0, 16'h0, "R2");
    // inner preempt and outer normal close together: outer wins, no flag (R5)
    apply(0, '0, 16'h0040, 16'h1000, "R5");
    // load while first level opened... reopen then collide load with a close (R8)
    apply(1, mkWord(16'h1200, 4'd2, 5'h00), 16'h0, 16'h0, "R2");
    apply(1, mkWord(16'h2200, 4'd4, 5'h00), 16'h0004, 16'h0, "R8");
    // level loaded while its own condition holds does not close that cycle (R9)
    apply(1, mkWord(16'h0777, 4'd8, 5'h00), 16'h0100, 16'h0777, "R9");
    apply(0, '0, 16'h0100, 16'h0, "R3");

    for (int c = 0; c < 6000; c++) begin
      logic        ld;
      logic [15:0] s;
      logic [15:0] pc;
      ld = ($urandom % 3) == 0;
      s  = (($urandom % 9) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      if (mDepth > 0 && ($urandom % 12) == 0) pc = mAddr[$urandom % mDepth];
      else pc = 16'($urandom);
      apply(ld, 25'($urandom), s, pc, "");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule